// File: doc/BRIEF.md
# Transactional Store Buffer with Framed Commit Drain

This block sits beside a processor core that runs code as speculative transactions. Every store the core issues while a transaction is open is captured in a small local buffer keyed by word address and never leaves the block on its own. A later store to an address the buffer already holds replaces the held data, so the buffer always holds exactly one word per written address. Loads made by the core are checked against the buffer, and a hit returns the buffered word, so the core sees its own uncommitted writes.

When the core signals the end of a transaction, the block raises a commit request toward a system-wide arbiter and holds it. Once a grant is sampled, the whole write set leaves as one contiguous commit packet of address/data beats, with a start marker on the first beat and an end marker on the last. Only the written words are sent. After the last beat the buffer empties itself and opens for the next transaction. A rollback pulse throws away the buffered stores and withdraws a pending request. Once the packet has started, the transaction counts as committed and rollback is ignored. A full flag tells the core that no new address fits, so it must close the transaction at that point.

The controller has three named states. OPEN collects stores. REQUEST holds the commit request. SEND streams the packet. The transitions are as follows. OPEN goes to REQUEST on an end-of-transaction pulse with a non-empty buffer. REQUEST goes to SEND when a grant is sampled. REQUEST goes to OPEN on rollback. SEND goes to OPEN after the end-marked beat.

Top module: `tcwb_top`

## Requirements
- R1: After reset the buffer is empty: `full`=0, `cm_req`=0, `pk_valid`=0, `st_ready`=1, and every load misses (`ld_hit`=0).
- R2: A store taken while OPEN (`st_valid` and `st_ready` both high at a clock edge) is held in the buffer. From the next cycle, a load of that address gives `ld_hit`=1 and the stored data. No packet beat appears before a grant.
- R3: A store to an address already buffered overwrites that word without using a new entry. Each address appears at most once in the packet, carrying its latest data.
- R4: `full` is 1 when DEPTH distinct addresses are held. `st_ready` is 0 while `full` is 1 or while the state is not OPEN.
- R5: An `tx_end` pulse in OPEN with a non-empty buffer raises `cm_req` on the next cycle. `cm_req` stays high until a grant is sampled or a rollback occurs. An `tx_end` pulse with an empty buffer is ignored.
- R6: `cm_grant` sampled high while `cm_req` is high starts the packet on the next cycle. The packet has one beat per held address, in the order each address was first written, on consecutive cycles. `pk_sop` marks only the first beat and `pk_eop` marks only the last.
- R7: On the cycle after the `pk_eop` beat, the buffer is empty, `pk_valid`=0, `st_ready`=1, and earlier addresses miss on load.
- R8: A `rollback` pulse in OPEN or REQUEST empties the buffer and drops `cm_req` on the next cycle. No packet follows.
- R9: A `rollback` pulse while the packet is being sent is ignored. The packet runs to its `pk_eop` beat with all entries.
- R10: A store offered while `st_ready`=0 is discarded. It never hits on load and never appears in a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by the core |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store can be taken this cycle |
| ld_addr | input | ADDR_W | Load address checked against the buffer |
| ld_hit | output | 1 | Load address is buffered |
| ld_data | output | DATA_W | Buffered data for a load hit |
| full | output | 1 | No free entry for a new address |
| tx_end | input | 1 | End-of-transaction pulse |
| rollback | input | 1 | Discard the current transaction |
| cm_req | output | 1 | Commit permission request |
| cm_grant | input | 1 | Commit permission from the arbiter |
| pk_valid | output | 1 | Packet beat valid |
| pk_sop | output | 1 | First beat of the packet |
| pk_eop | output | 1 | Last beat of the packet |
| pk_addr | output | ADDR_W | Beat address |
| pk_data | output | DATA_W | Beat data |

## Verification
A store taken at an edge is visible on the combinational load port in the cycle after that edge. `full` and `st_ready` follow in that same cycle. `cm_req` rises one cycle after the `tx_end` edge. The first beat is out one cycle after the edge that samples the grant, and the buffer is empty one cycle after the end-marked edge. A rollback takes effect one cycle after its edge. The bench drives every input on the falling edge and samples the outputs on the falling edge after the rising edge concerned, so each check falls in the cycle where its result is due. Packet beats are compared one per falling edge against an order-preserving reference list that the bench builds from its own stores.

// File: rtl/tcwb_pkg.sv
package tcwb_pkg;
    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_SEND    = 2'd2
    } tcwb_state_e;
endpackage

// File: rtl/tcwb_store.sv
module tcwb_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [CNT_W-1:0]  count_q;
    logic              wr_hit;
    logic [IDX_W-1:0]  wr_pos;
    logic [IDX_W-1:0]  ld_pos;

    // Address match over the occupied entries, one lookup per port
    always_comb begin
        wr_hit = 1'b0;
        wr_pos = '0;
        ld_hit = 1'b0;
        ld_pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < count_q && addr_q[i] == wr_addr) begin
                wr_hit = 1'b1;
                wr_pos = IDX_W'(i);
            end
            if (CNT_W'(i) < count_q && addr_q[i] == ld_addr) begin
                ld_hit = 1'b1;
                ld_pos = IDX_W'(i);
            end
        end
    end

    assign ld_data = data_q[ld_pos];
    assign rd_addr = addr_q[rd_idx];
    assign rd_data = data_q[rd_idx];
    assign count   = count_q;
    assign full    = (count_q == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (wr_en && !wr_hit && count_q < CNT_W'(DEPTH)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Storage needs no reset: occupancy is governed by count_q
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            if (wr_hit) begin
                data_q[wr_pos] <= wr_data;
            end else if (count_q < CNT_W'(DEPTH)) begin
                addr_q[count_q[IDX_W-1:0]] <= wr_addr;
                data_q[count_q[IDX_W-1:0]] <= wr_data;
            end
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R4
    AST_MERGE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && !clr) |=> count_q == $past(count_q)); // R3
endmodule

// File: rtl/tcwb_ctrl.sv
module tcwb_ctrl
    import tcwb_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_end,
    input  logic             rollback,
    input  logic             cm_grant,
    input  logic [CNT_W-1:0] count,
    output logic             open,
    output logic             clr,
    output logic             cm_req,
    output logic             pk_valid,
    output logic             pk_sop,
    output logic             pk_eop,
    output logic [IDX_W-1:0] rd_idx
);
    tcwb_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             last_beat;

    assign last_beat = (CNT_W'(idx_q) == count - 1'b1);

    // State register and beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_q == ST_SEND && !last_beat) ? idx_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:    if (!rollback && tx_end && count != '0) state_d = ST_REQUEST;
            ST_REQUEST: if (rollback) state_d = ST_OPEN;
                        else if (cm_grant) state_d = ST_SEND;
            ST_SEND:    if (last_beat) state_d = ST_OPEN;
            default:    state_d = ST_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        open     = (state_q == ST_OPEN);
        cm_req   = (state_q == ST_REQUEST);
        pk_valid = (state_q == ST_SEND);
        pk_sop   = pk_valid && (idx_q == '0);
        pk_eop   = pk_valid && last_beat;
        rd_idx   = idx_q;
        clr      = (rollback && state_q != ST_SEND) || pk_eop;
    end

    AST_PKT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pk_valid) |-> $past(cm_grant) && $past(cm_req)); // R6
    AST_SOP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pk_valid) |-> pk_sop); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_req && !cm_grant && !rollback) |=> cm_req); // R5
    AST_ROLLBACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !pk_valid) |=> !cm_req && !pk_valid && count == '0); // R8
    AST_SEND_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && !pk_eop) |=> pk_valid); // R9
    AST_EOP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && pk_eop) |=> open && count == '0); // R7
endmodule

// File: rtl/tcwb_top.sv
module tcwb_top #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              full,
    input  logic              tx_end,
    input  logic              rollback,
    output logic              cm_req,
    input  logic              cm_grant,
    output logic              pk_valid,
    output logic              pk_sop,
    output logic              pk_eop,
    output logic [ADDR_W-1:0] pk_addr,
    output logic [DATA_W-1:0] pk_data
);
    logic             open, clr, wr_en;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] count;

    assign st_ready = open && !full;
    assign wr_en    = st_valid && st_ready;

    tcwb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(st_addr), .wr_data(st_data), .clr(clr),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_addr(pk_addr), .rd_data(pk_data),
        .count(count), .full(full)
    );

    tcwb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .tx_end(tx_end), .rollback(rollback), .cm_grant(cm_grant),
        .count(count), .open(open), .clr(clr), .cm_req(cm_req),
        .pk_valid(pk_valid), .pk_sop(pk_sop), .pk_eop(pk_eop),
        .rd_idx(rd_idx)
    );

    AST_NO_STORE_WHEN_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_req || pk_valid) |-> !st_ready); // R10
endmodule

// File: tb/tcwb_top_tb_top.sv
module tcwb_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;

    // Stimulus table: {address, data}; the lookup result expected after each
    // store is the data of that same row.
    localparam logic [47:0] VEC [8] = '{
        {16'h0010, 32'hA000_0001}, {16'h0020, 32'hA000_0002},
        {16'h0030, 32'hA000_0003}, {16'h0020, 32'hB000_0002},
        {16'h0040, 32'hA000_0004}, {16'h0010, 32'hB000_0001},
        {16'h0050, 32'hA000_0005}, {16'h0060, 32'hA000_0006}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 1'b0, tx_end = 1'b0, rollback = 1'b0, cm_grant = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic st_ready, ld_hit, full, cm_req, pk_valid, pk_sop, pk_eop;
    logic [DATA_W-1:0] ld_data, pk_data;
    logic [ADDR_W-1:0] pk_addr;

    int n_checks = 0, n_fails = 0;
    logic [ADDR_W-1:0] m_addr [DEPTH];
    logic [DATA_W-1:0] m_data [DEPTH];
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcwb_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_data(ld_data), .full(full), .tx_end(tx_end),
        .rollback(rollback), .cm_req(cm_req), .cm_grant(cm_grant),
        .pk_valid(pk_valid), .pk_sop(pk_sop), .pk_eop(pk_eop),
        .pk_addr(pk_addr), .pk_data(pk_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic model_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        for (int i = 0; i < m_cnt; i++) begin
            if (m_addr[i] == a) begin
                m_data[i] = d;
                return;
            end
        end
        m_addr[m_cnt] = a;
        m_data[m_cnt] = d;
        m_cnt++;
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        tick();
        st_valid = 1'b0;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input bit exp_hit,
                         input logic [DATA_W-1:0] exp_d, input string req);
        ld_addr = a;
        #1;
        check(ld_hit == exp_hit, req, 64'(ld_hit), 64'(exp_hit));
        if (exp_hit) check(ld_data == exp_d, req, 64'(ld_data), 64'(exp_d));
    endtask

    // Grant at a falling edge, then compare every beat with the model list
    task automatic drain(input bit rb_mid, input string req);
        cm_grant = 1'b1;
        tick();
        cm_grant = 1'b0;
        for (int b = 0; b < m_cnt; b++) begin
            check(pk_valid == 1'b1, req, 64'(pk_valid), 64'd1);
            check(pk_sop == (b == 0), req, 64'(pk_sop), 64'(b == 0));
            check(pk_eop == (b == m_cnt - 1), req, 64'(pk_eop), 64'(b == m_cnt - 1));
            check(pk_addr == m_addr[b], req, 64'(pk_addr), 64'(m_addr[b]));
            check(pk_data == m_data[b], req, 64'(pk_data), 64'(m_data[b]));
            rollback = rb_mid && (b == 1);
            tick();
        end
        rollback = 1'b0;
        m_cnt = 0;
        check(pk_valid == 1'b0, "R7 idle after eop", 64'(pk_valid), 64'd0);
        check(st_ready == 1'b1, "R7 open after eop", 64'(st_ready), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(full == 1'b0, "R1 full", 64'(full), 64'd0);
        check(cm_req == 1'b0, "R1 cm_req", 64'(cm_req), 64'd0);
        check(pk_valid == 1'b0, "R1 pk_valid", 64'(pk_valid), 64'd0);
        check(st_ready == 1'b1, "R1 st_ready", 64'(st_ready), 64'd1);
        probe(16'h0010, 1'b0, '0, "R1 load miss");

        // Table walk: R2 forwarding, R3 overwrite
        for (int v = 0; v < 8; v++) begin
            do_store(VEC[v][47:32], VEC[v][31:0]);
            model_store(VEC[v][47:32], VEC[v][31:0]);
            probe(VEC[v][47:32], 1'b1, VEC[v][31:0], "R2/R3 load forward");
            check(pk_valid == 1'b0, "R2 no beat before grant", 64'(pk_valid), 64'd0);
        end
        probe(16'h0020, 1'b1, 32'hB000_0002, "R3 latest data kept");

        // R5 request and hold
        tx_end = 1'b1; tick(); tx_end = 1'b0;
        check(cm_req == 1'b1, "R5 request raised", 64'(cm_req), 64'd1);
        // R10 stores refused while waiting
        check(st_ready == 1'b0, "R4 not ready in request", 64'(st_ready), 64'd0);
        do_store(16'h0070, 32'hDEAD_0007);
        check(cm_req == 1'b1, "R5 request held", 64'(cm_req), 64'd1);
        check(pk_valid == 1'b0, "R2 no beat without grant", 64'(pk_valid), 64'd0);
        probe(16'h0070, 1'b0, '0, "R10 refused store absent");
        drain(1'b0, "R6 packet");
        probe(16'h0010, 1'b0, '0, "R7 emptied");

        // R5 empty end ignored
        tx_end = 1'b1; tick(); tx_end = 1'b0;
        check(cm_req == 1'b0, "R5 empty end ignored", 64'(cm_req), 64'd0);

        // R4 full
        for (int i = 0; i < DEPTH; i++) begin
            do_store(16'h0100 + 16'(i), 32'hC000_0000 + 32'(i));
            model_store(16'h0100 + 16'(i), 32'hC000_0000 + 32'(i));
        end
        check(full == 1'b1, "R4 full", 64'(full), 64'd1);
        check(st_ready == 1'b0, "R4 not ready when full", 64'(st_ready), 64'd0);
        do_store(16'h0200, 32'h1234_5678);
        probe(16'h0200, 1'b0, '0, "R10 store when full dropped");

        // R8 rollback in request
        tx_end = 1'b1; tick(); tx_end = 1'b0;
        check(cm_req == 1'b1, "R5 request on full", 64'(cm_req), 64'd1);
        rollback = 1'b1; tick(); rollback = 1'b0;
        m_cnt = 0;
        check(cm_req == 1'b0, "R8 request dropped", 64'(cm_req), 64'd0);
        check(full == 1'b0, "R8 buffer emptied", 64'(full), 64'd0);
        probe(16'h0103, 1'b0, '0, "R8 entry gone");
        cm_grant = 1'b1; tick(); cm_grant = 1'b0;
        check(pk_valid == 1'b0, "R8 no packet after rollback", 64'(pk_valid), 64'd0);

        // R8 rollback while open
        do_store(16'h0300, 32'h0000_0300);
        do_store(16'h0301, 32'h0000_0301);
        rollback = 1'b1; tick(); rollback = 1'b0;
        probe(16'h0300, 1'b0, '0, "R8 open rollback");
        tx_end = 1'b1; tick(); tx_end = 1'b0;
        check(cm_req == 1'b0, "R8 nothing left to commit", 64'(cm_req), 64'd0);

        // R9 rollback during send ignored
        for (int i = 0; i < 3; i++) begin
            do_store(16'h0400 + 16'(i), 32'hE000_0000 + 32'(i));
            model_store(16'h0400 + 16'(i), 32'hE000_0000 + 32'(i));
        end
        tx_end = 1'b1; tick(); tx_end = 1'b0;
        drain(1'b1, "R9 packet survives rollback");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule